// File: doc/BRIEF.md
# Multi-Channel DMA Request Arbiter

This block is the request front end of a four-channel DMA engine. Each channel picks one of four request lines. A rising edge on the chosen line is held in a sticky pending flag until that channel's transfer finishes. A fixed-priority encoder compares the pending flags of the enabled channels. A small sequencer grants the winning channel to the transfer engine, waits for the engine to report completion, and then returns a single-cycle acknowledge to the requesting channel.

A channel can also be set to bypass. In that mode a request edge produces only an interrupt pulse for that channel and never reaches arbitration. The block does not drive the bus transfer itself. The engine reads `req_ch_o` while `req_valid_o` is high and reports completion on `xfer_done_i`.

All state resets synchronously through the active-high `rst`.

Top module: `dma_req_arbiter`

## Requirements
- R1: Channel c uses request line `src_req_i[c*4 + s]`, where s is the 2-bit field `src_sel_i[2c+1:2c]`. The other three lines of that channel have no effect on it.
- R2: A 0-to-1 change of the selected line, seen at a clock edge, sets the channel's pending flag when bypass is clear. A change of selection that takes the selected value from 0 to 1 also counts. A line held high sets nothing more. The flag clears when that channel's transfer completes.
- R3: A pending flag on a disabled channel (`ch_en_i[c]`=0) is never granted but is kept. Enabling the channel later lets it compete.
- R4: With `ch_byp_i[c]`=1, each selected rising edge gives a pulse on `ch_irq_o[c]` in the following cycle, lasting exactly one cycle. This happens whatever the enable bit is, and no pending flag is set.
- R5: When several enabled channels are pending, the lowest channel number is granted first.
- R6: `ch_acks_o` pulses the bit of the finished channel for exactly one cycle, in the cycle after `xfer_done_i` is accepted. At most one bit is ever high.
- R7: `xfer_done_i` is accepted only while `req_valid_o` is high. While `req_valid_o` is low it has no effect.
- R8: A new grant is made only when no grant is active. While `req_valid_o` is high, `req_ch_o` holds its value until completion. `req_valid_o` is low whenever no grant is active.
- R9: If a new edge on a channel arrives in the same cycle as that channel's completion, the completion clears the flag. The new edge then sets the flag one cycle later, which leads to a fresh grant.
- R10: An edge sampled at clock k on an enabled channel, with the sequencer idle, raises `req_valid_o` after clock k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req_i | input | 16 | Request lines, four per channel, bit c*4+s |
| src_sel_i | input | 8 | Source select, 2 bits per channel |
| ch_en_i | input | 4 | Per-channel arbitration enable |
| ch_byp_i | input | 4 | Per-channel bypass-to-interrupt |
| xfer_done_i | input | 1 | Transfer engine reports completion |
| req_valid_o | output | 1 | A channel is granted |
| req_ch_o | output | 2 | Granted channel number |
| ch_acks_o | output | 4 | One-cycle acknowledge per channel |
| ch_irq_o | output | 4 | One-cycle bypass interrupt per channel |

## Verification
Directed cases cover the following:
- toggling an unselected line, which separates a working source selector from one that listens to all inputs;
- simultaneous requests, which show whether the priority order is correct;
- a higher-priority request arriving mid-transfer, which separates holding the grant from re-arbitrating;
- a line held high after completion, which separates edge capture from level capture;
- an edge coinciding with completion, which shows whether the deferred capture works.

A random phase then changes lines, selections, enables and bypass bits, and issues completions at random times. This includes completions while idle. The outputs are compared every cycle against a cycle model built from the requirements.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int unsigned DEF_NUM_CH  = 4;
    localparam int unsigned DEF_NUM_SRC = 4;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_GRANT = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

    // Per-channel event record produced by the source stage
    typedef struct packed {
        logic rise;   // selected line went 0 -> 1
        logic arm;    // rise destined for arbitration
        logic intr;   // rise destined for interrupt
    } chan_evt_t;

    function automatic chan_evt_t classify_edge(input logic cur, input logic prev,
                                                input logic byp);
        chan_evt_t e;
        e.rise = cur & ~prev;
        e.arm  = e.rise & ~byp;
        e.intr = e.rise & byp;
        return e;
    endfunction

endpackage

// File: rtl/dma_src_chan.sv
module dma_src_chan
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src,
    input  logic [SEL_W-1:0]   sel,
    input  logic               byp,
    input  logic               clr,
    output logic               pend,
    output logic               irq
);

    logic      sel_line;
    logic      prev_q;
    logic      defer_q;
    logic      pend_q;
    logic      irq_q;
    chan_evt_t evt;

    assign sel_line = src[sel];
    assign evt      = classify_edge(sel_line, prev_q, byp);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            defer_q <= 1'b0;
            pend_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            prev_q  <= sel_line;
            irq_q   <= evt.intr;
            // completion wins; a coinciding edge is replayed next cycle
            defer_q <= clr & evt.arm;
            if (clr) pend_q <= 1'b0;
            else     pend_q <= pend_q | evt.arm | defer_q;
        end
    end

    assign pend = pend_q;
    assign irq  = irq_q;

endmodule

// File: rtl/dma_prio_enc.sv
module dma_prio_enc #(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] req,
    output logic              any,
    output logic [CH_W-1:0]   idx
);

    always_comb begin
        any = |req;
        idx = '0;
        // scan downward so the lowest set index is the last written
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) idx = CH_W'(i);
        end
    end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any,
    input  logic [CH_W-1:0]   win_idx,
    input  logic              done,
    output logic              valid,
    output logic [CH_W-1:0]   ch,
    output logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] ack
);

    seq_state_e          state_q, state_d;
    logic [CH_W-1:0]     ch_q;
    logic [NUM_CH-1:0]   ack_q;
    logic                finish;

    assign valid  = (state_q != SQ_IDLE);
    assign finish = valid & done;
    assign clr    = finish ? (NUM_CH'(1) << ch_q) : '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (any)  state_d = SQ_GRANT;
            SQ_GRANT: state_d = done ? SQ_IDLE : SQ_WAIT;
            SQ_WAIT:  if (done) state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            ch_q    <= '0;
            ack_q   <= '0;
        end else begin
            state_q <= state_d;
            ack_q   <= clr;
            if (state_q == SQ_IDLE && any) ch_q <= win_idx;
        end
    end

    assign ch  = ch_q;
    assign ack = ack_q;

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH  = DEF_NUM_CH,
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CH*NUM_SRC-1:0] src_req_i,
    input  logic [NUM_CH*SEL_W-1:0]   src_sel_i,
    input  logic [NUM_CH-1:0]         ch_en_i,
    input  logic [NUM_CH-1:0]         ch_byp_i,
    input  logic                      xfer_done_i,
    output logic                      req_valid_o,
    output logic [CH_W-1:0]           req_ch_o,
    output logic [NUM_CH-1:0]         ch_acks_o,
    output logic [NUM_CH-1:0]         ch_irq_o
);

    logic [NUM_CH-1:0] pend_w;
    logic [NUM_CH-1:0] clr_w;
    logic [NUM_CH-1:0] active_w;
    logic              any_w;
    logic [CH_W-1:0]   win_w;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dma_src_chan #(.NUM_SRC(NUM_SRC)) u_chan (
            .clk  (clk),
            .rst  (rst),
            .src  (src_req_i[c*NUM_SRC +: NUM_SRC]),
            .sel  (src_sel_i[c*SEL_W +: SEL_W]),
            .byp  (ch_byp_i[c]),
            .clr  (clr_w[c]),
            .pend (pend_w[c]),
            .irq  (ch_irq_o[c])
        );
    end

    assign active_w = pend_w & ch_en_i;

    dma_prio_enc #(.NUM_CH(NUM_CH)) u_enc (
        .req (active_w),
        .any (any_w),
        .idx (win_w)
    );

    dma_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .any     (any_w),
        .win_idx (win_w),
        .done    (xfer_done_i),
        .valid   (req_valid_o),
        .ch      (req_ch_o),
        .clr     (clr_w),
        .ack     (ch_acks_o)
    );

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] ch_en_i,
    input logic [NUM_CH-1:0] ch_byp_i,
    input logic              xfer_done_i,
    input logic              req_valid_o,
    input logic [CH_W-1:0]   req_ch_o,
    input logic [NUM_CH-1:0] ch_acks_o,
    input logic [NUM_CH-1:0] ch_irq_o
);

    logic [NUM_CH-1:0] en_q;
    always_ff @(posedge clk) en_q <= ch_en_i;

    a_r6_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_acks_o));

    a_r8_hold_grant: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !xfer_done_i) |=> (req_valid_o && $stable(req_ch_o)));

    a_r6_ack_after_done: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && xfer_done_i) |=>
            (!req_valid_o && ch_acks_o == (NUM_CH'(1) << $past(req_ch_o))));

    a_r7_ack_needs_grant: assert property (@(posedge clk) disable iff (rst)
        (|ch_acks_o) |-> $past(req_valid_o && xfer_done_i));

    a_r4_irq_needs_bypass: assert property (@(posedge clk) disable iff (rst)
        (ch_irq_o & ~$past(ch_byp_i)) == '0);

    a_r3_grant_enabled: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid_o) |-> en_q[req_ch_o]);

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ch_en_i     (ch_en_i),
    .ch_byp_i    (ch_byp_i),
    .xfer_done_i (xfer_done_i),
    .req_valid_o (req_valid_o),
    .req_ch_o    (req_ch_o),
    .ch_acks_o   (ch_acks_o),
    .ch_irq_o    (ch_irq_o)
);

// File: tb/dma_req_arbiter_tb.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb;

    localparam int NCH = 4;
    localparam int NSRC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_req = '0;
    logic [7:0]  src_sel = '0;
    logic [3:0]  en = 4'hF;
    logic [3:0]  byp = '0;
    logic        done = 1'b0;
    logic        valid;
    logic [1:0]  chn;
    logic [3:0]  ack;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dma_req_arbiter u_dut (
        .clk(clk), .rst(rst), .src_req_i(src_req), .src_sel_i(src_sel),
        .ch_en_i(en), .ch_byp_i(byp), .xfer_done_i(done),
        .req_valid_o(valid), .req_ch_o(chn), .ch_acks_o(ack), .ch_irq_o(irq)
    );

    // ---------------- reference cycle model ----------------
    logic [3:0] m_prev, m_pend, m_def, m_ack, m_irq;
    logic       m_valid;
    logic [1:0] m_ch;

    function automatic logic [3:0] sel_lines(input logic [15:0] s, input logic [7:0] sl);
        logic [3:0] r;
        for (int c = 0; c < NCH; c++) r[c] = s[c*NSRC + int'(sl[c*2 +: 2])];
        return r;
    endfunction

    function automatic logic [1:0] lowest(input logic [3:0] v);
        for (int c = 0; c < NCH; c++) if (v[c]) return 2'(c);
        return 2'd0;
    endfunction

    always @(posedge clk) begin
        logic [3:0] cur, rise, arm, clr;
        if (rst) begin
            m_prev <= '0; m_pend <= '0; m_def <= '0; m_ack <= '0; m_irq <= '0;
            m_valid <= 1'b0; m_ch <= '0;
        end else begin
            cur  = sel_lines(src_req, src_sel);
            rise = cur & ~m_prev;
            arm  = rise & ~byp;
            clr  = (m_valid && done) ? (4'b1 << m_ch) : 4'b0;
            m_prev <= cur;
            m_irq  <= rise & byp;
            m_ack  <= clr;
            m_def  <= clr & arm;
            m_pend <= (m_pend | arm | m_def) & ~clr;
            if (!m_valid) begin
                if (|(m_pend & en)) begin
                    m_valid <= 1'b1;
                    m_ch    <= lowest(m_pend & en);
                end
            end else if (done) begin
                m_valid <= 1'b0;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_grant();
        done = 1'b1; tick(); done = 1'b0; tick();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    // ---------------- stimulus ----------------
    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        // R8 reset state
        chk("R8 reset valid", valid, 0);
        chk("R6 reset ack", ack, 0);
        chk("R4 reset irq", irq, 0);

        // R1: channel 2 selects source 1; unselected line ignored
        src_sel[5:4] = 2'd1; tick();
        src_req[8] = 1'b1; tick(3);
        chk("R1 unselected line", valid, 0);
        src_req[8] = 1'b0;
        src_req[9] = 1'b1; tick(2);
        chk("R10 latency valid", valid, 1);
        chk("R1 selected ch", chn, 2);

        // R8: higher priority arrives mid-transfer; grant held
        src_req[0] = 1'b1; tick(3);
        chk("R8 hold valid", valid, 1);
        chk("R8 hold ch", chn, 2);

        // R6: acknowledge pulse
        done = 1'b1; tick();
        chk("R6 ack ch2", ack, 4'b0100);
        chk("R8 valid drops", valid, 0);
        done = 1'b0; tick();
        chk("R6 ack one cycle", ack, 0);
        chk("R5 next grant ch0", chn, 0);
        chk("R8 regrant valid", valid, 1);
        done = 1'b1; tick();
        chk("R6 ack ch0", ack, 4'b0001);
        done = 1'b0; tick(3);
        chk("R2 held level no rearm", valid, 0);
        src_req = '0; tick(2);

        // R5: simultaneous ch1 and ch3
        src_req[4] = 1'b1; src_req[12] = 1'b1; tick(2);
        chk("R5 priority ch1", chn, 1);
        chk("R5 priority valid", valid, 1);
        done = 1'b1; tick();
        chk("R6 ack ch1", ack, 4'b0010);
        done = 1'b0; tick();
        chk("R5 then ch3", chn, 3);
        finish_grant();
        src_req = '0; tick(2);

        // R3: disabled channel keeps pending
        en[3] = 1'b0;
        src_req[12] = 1'b1; tick(4);
        chk("R3 disabled not granted", valid, 0);
        en[3] = 1'b1; tick();
        chk("R3 enabled granted", valid, 1);
        chk("R3 enabled ch", chn, 3);
        finish_grant();
        src_req = '0; tick(2);

        // R4: bypass to interrupt, independent of enable
        byp[1] = 1'b1; en[1] = 1'b0;
        src_req[4] = 1'b1; tick();
        chk("R4 irq pulse", irq, 4'b0010);
        tick();
        chk("R4 irq one cycle", irq, 0);
        tick();
        chk("R4 no dma request", valid, 0);
        byp[1] = 1'b0; en[1] = 1'b1; tick(3);
        chk("R2 no edge no pend", valid, 0);
        src_req = '0; tick(2);

        // R7: completion while idle ignored
        done = 1'b1; tick();
        chk("R7 idle done no ack", ack, 0);
        done = 1'b0; tick();

        // R9: edge coinciding with completion
        src_req[0] = 1'b1; tick(2);
        chk("R9 setup grant", valid, 1);
        src_req[0] = 1'b0; tick();
        src_req[0] = 1'b1; done = 1'b1; tick();
        chk("R9 ack", ack, 4'b0001);
        done = 1'b0; tick();
        chk("R9 clear wins", valid, 0);
        tick();
        chk("R9 replay valid", valid, 1);
        chk("R9 replay ch", chn, 0);
        finish_grant();
        src_req = '0; tick(2);

        // random phase against the cycle model
        void'($urandom(32'd20240611));
        for (int cyc = 0; cyc < 4000; cyc++) begin
            chk("R8 rand valid", valid, m_valid);
            if (m_valid) chk("R8 rand ch", chn, m_ch);
            chk("R6 rand ack", ack, m_ack);
            chk("R4 rand irq", irq, m_irq);
            for (int b = 0; b < 16; b++) if ($urandom % 8 == 0) src_req[b] = ~src_req[b];
            if ($urandom % 32 == 0) src_sel[($urandom % 4)*2 +: 2] = 2'($urandom);
            if ($urandom % 40 == 0) en[$urandom % 4] = ~en[$urandom % 4];
            if ($urandom % 40 == 0) byp[$urandom % 4] = ~byp[$urandom % 4];
            done = m_valid ? ($urandom % 3 == 0) : ($urandom % 16 == 0);
            tick();
        end
        summary();
    end

endmodule